// File: doc/BRIEF.md
# Encrypted Four-Channel Data Path Selector

This block moves one of four data channels across a short registered link to one of four receivers, with each word masked on the way. Every input channel is combined by bitwise XOR with its own sender key. A source select then picks one of the four masked words and places it on the link. The link is two register stages deep. At the far end, a destination select steers the word to one of four output channels, and that output's receiver key removes the mask by a second XOR.

The cipher is symmetric. A word comes out as plain data only when the receiver key on its output equals the sender key that masked it. The link delays each word by two cycles, so the destination select and the receiver keys are read in the cycle the word arrives, not in the cycle it was sent. A valid bit travels with each word. Each output has its own valid flag, and any output that is not receiving a valid word is driven to zero.

Top module: `crypt_route4`

## Requirements
- R1: A synchronous active-high reset clears both link stages. In the cycle after any reset cycle, every output valid flag is 0 and every output word is 0.
- R2: Each input lane j is masked as data_j XOR tx_key_j before selection. Lane j occupies bits [j*DW +: DW] of the packed buses, with lane 0 = A, 1 = B, 2 = C and 3 = D.
- R3: Source select value s (0 = A, 1 = B, 2 = C, 3 = D) places exactly the masked word of lane s on the link.
- R4: A word and its valid bit sampled at clock edge k appear at the outputs right after edge k+1. That is a latency of exactly two register stages. No earlier or later delivery occurs.
- R5: When an arriving word is valid, only output valid bit d is set, where d is the destination select value (0 = A … 3 = D). The destination select is independent of the source select.
- R6: Every output whose valid flag is 0 drives an all-zero word.
- R7: The destination select and the receiver keys are applied combinationally to the word leaving the link. They are the values present in the arrival cycle, not those of the send cycle.
- R8: When the receiver key of the chosen output equals the sender key that masked the word, the output equals the original plain input word.
- R9: Any output valid flag is set only when the word leaving the link was sent with its input valid high.
- R10: With A=8'h0F, B=8'hF0, C=8'h00, D=8'hFF, all keys 8'h0F, source select 2 and destination select 3, output D shows 8'h00 with its valid flag set two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | The word chosen this cycle is valid |
| in_words | input | 4*DW | Plain input lanes A..D, packed |
| tx_keys | input | 4*DW | Sender keys per input lane, packed |
| src_sel | input | 2 | Source lane select |
| dst_sel | input | 2 | Destination output select, arrival cycle |
| rx_keys | input | 4*DW | Receiver keys per output lane, arrival cycle |
| out_words | output | 4*DW | Unmasked output lanes A..D, packed |
| out_valid | output | 4 | Per-output valid flags |

## Verification
The assertions assume that the selects are always known 2-bit values. They also assume that reset is held for at least one edge before data flows, so the two-cycle history they compare against never reaches back before reset. The stimulus drives every select and key from defined values from the first cycle and holds reset over the opening edges. Between edges, selects, keys and valid are changed freely, including back-to-back changes of both selects. This exercises the arrival-cycle timing without breaking those assumptions.

// File: rtl/crypt_route_pkg.sv
package crypt_route_pkg;
  localparam int NCH  = 4;
  localparam int SELW = 2;

  function automatic logic [NCH-1:0] sel_onehot(input logic [SELW-1:0] s);
    logic [NCH-1:0] r;
    r = '0;
    r[s] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/chan_encrypt.sv
module chan_encrypt #(
  parameter int DW  = 8,
  parameter int NCH = 4
) (
  input  logic [NCH*DW-1:0] plain_words,
  input  logic [NCH*DW-1:0] key_words,
  output logic [NCH*DW-1:0] cipher_words
);
  function automatic logic [DW-1:0] mask_word(input logic [DW-1:0] d, input logic [DW-1:0] k);
    return d ^ k;
  endfunction

  for (genvar j = 0; j < NCH; j++) begin : g_lane
    assign cipher_words[j*DW +: DW] = mask_word(plain_words[j*DW +: DW], key_words[j*DW +: DW]);
  end
endmodule

// File: rtl/src_mux.sv
module src_mux #(
  parameter int DW   = 8,
  parameter int NCH  = 4,
  parameter int SELW = 2
) (
  input  logic [NCH*DW-1:0] lane_words,
  input  logic [SELW-1:0]   sel,
  output logic [DW-1:0]     picked
);
  always_comb begin
    picked = '0;
    for (int j = 0; j < NCH; j++) begin
      if (sel == SELW'(j)) picked = lane_words[j*DW +: DW];
    end
  end
endmodule

// File: rtl/link_pipe.sv
module link_pipe #(
  parameter int DW    = 8,
  parameter int DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          head_valid,
  input  logic [DW-1:0] head_word,
  output logic          tail_valid,
  output logic [DW-1:0] tail_word
);
  logic [DEPTH:0]         v_c;
  logic [DEPTH:0][DW-1:0] w_c;

  assign v_c[0] = head_valid;
  assign w_c[0] = head_word;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) begin
        v_c[g+1] <= 1'b0;
        w_c[g+1] <= '0;
      end else begin
        v_c[g+1] <= v_c[g];
        w_c[g+1] <= w_c[g];
      end
    end
  end

  assign tail_valid = v_c[DEPTH];
  assign tail_word  = w_c[DEPTH];
endmodule

// File: rtl/dst_steer.sv
module dst_steer
  import crypt_route_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              arr_valid,
  input  logic [DW-1:0]     arr_word,
  input  logic [SELW-1:0]   sel,
  input  logic [NCH*DW-1:0] key_words,
  output logic [NCH*DW-1:0] lane_words,
  output logic [NCH-1:0]    lane_valid
);
  function automatic logic [DW-1:0] unmask_word(input logic [DW-1:0] c, input logic [DW-1:0] k);
    return c ^ k;
  endfunction

  logic [NCH-1:0] pick;
  assign pick = arr_valid ? sel_onehot(sel) : '0;

  for (genvar j = 0; j < NCH; j++) begin : g_out
    assign lane_valid[j]         = pick[j];
    assign lane_words[j*DW +: DW] = pick[j] ? unmask_word(arr_word, key_words[j*DW +: DW]) : '0;
  end
endmodule

// File: rtl/crypt_route4.sv
module crypt_route4
  import crypt_route_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [NCH*DW-1:0] in_words,
  input  logic [NCH*DW-1:0] tx_keys,
  input  logic [SELW-1:0]   src_sel,
  input  logic [SELW-1:0]   dst_sel,
  input  logic [NCH*DW-1:0] rx_keys,
  output logic [NCH*DW-1:0] out_words,
  output logic [NCH-1:0]    out_valid
);
  localparam int LINK_LAT = 2;

  logic [NCH*DW-1:0] cipher_lanes;
  logic [DW-1:0]     cipher_sel;
  logic              link_valid;
  logic [DW-1:0]     link_word;

  chan_encrypt #(.DW(DW), .NCH(NCH)) u_enc (
    .plain_words (in_words),
    .key_words   (tx_keys),
    .cipher_words(cipher_lanes)
  );

  src_mux #(.DW(DW), .NCH(NCH), .SELW(SELW)) u_mux (
    .lane_words(cipher_lanes),
    .sel       (src_sel),
    .picked    (cipher_sel)
  );

  link_pipe #(.DW(DW), .DEPTH(LINK_LAT)) u_link (
    .clk       (clk),
    .rst       (rst),
    .head_valid(in_valid),
    .head_word (cipher_sel),
    .tail_valid(link_valid),
    .tail_word (link_word)
  );

  dst_steer #(.DW(DW)) u_steer (
    .arr_valid (link_valid),
    .arr_word  (link_word),
    .sel       (dst_sel),
    .key_words (rx_keys),
    .lane_words(out_words),
    .lane_valid(out_valid)
  );
endmodule

// File: rtl/crypt_route4_chk.sv
module crypt_route4_chk
  import crypt_route_pkg::*;
#(
  parameter int DW = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [NCH*DW-1:0] in_words,
  input logic [NCH*DW-1:0] tx_keys,
  input logic [SELW-1:0]   src_sel,
  input logic [SELW-1:0]   dst_sel,
  input logic [DW-1:0]     cipher_sel,
  input logic              link_valid,
  input logic [DW-1:0]     link_word,
  input logic [NCH*DW-1:0] out_words,
  input logic [NCH-1:0]    out_valid
);
  assert_reset_clear_R1: assert property (@(posedge clk) rst |=> (out_valid == '0));

  assert_mask_sel_R3: assert property (@(posedge clk) disable iff (rst)
    cipher_sel == (in_words[src_sel*DW +: DW] ^ tx_keys[src_sel*DW +: DW]));

  assert_link_word_R4: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (link_word == $past(cipher_sel, 2)));

  assert_link_valid_R9: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> $past(in_valid, 2));

  assert_onehot_R5: assert property (@(posedge clk) disable iff (rst) $onehot0(out_valid));

  assert_route_R5: assert property (@(posedge clk) disable iff (rst)
    link_valid |-> (out_valid == sel_onehot(dst_sel)));

  assert_valid_flag_R9: assert property (@(posedge clk) disable iff (rst)
    (|out_valid) == link_valid);

  for (genvar j = 0; j < NCH; j++) begin : g_lane_chk
    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (rst)
      !out_valid[j] |-> (out_words[j*DW +: DW] == '0));
  end
endmodule

bind crypt_route4 crypt_route4_chk #(.DW(DW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_words  (in_words),
  .tx_keys   (tx_keys),
  .src_sel   (src_sel),
  .dst_sel   (dst_sel),
  .cipher_sel(cipher_sel),
  .link_valid(link_valid),
  .link_word (link_word),
  .out_words (out_words),
  .out_valid (out_valid)
);

// File: tb/crypt_route4_test.sv
module crypt_route4_test;
  localparam int DW  = 8;
  localparam int NCH = 4;
  localparam int BW  = NCH*DW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [BW-1:0] in_words = '0;
  logic [BW-1:0] tx_keys  = '0;
  logic [1:0]    src_sel  = '0;
  logic [1:0]    dst_sel  = '0;
  logic [BW-1:0] rx_keys  = '0;
  logic [BW-1:0] out_words;
  logic [NCH-1:0] out_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  crypt_route4 #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words),
    .tx_keys(tx_keys), .src_sel(src_sel), .dst_sel(dst_sel),
    .rx_keys(rx_keys), .out_words(out_words), .out_valid(out_valid)
  );

  // reference: two-deep history of masked words
  logic          mv0 = 0, mv1 = 0;
  logic [DW-1:0] mw0 = '0, mw1 = '0;
  always @(posedge clk) begin
    if (rst) begin
      mv0 <= 0; mv1 <= 0; mw0 <= '0; mw1 <= '0;
    end else begin
      mv1 <= mv0; mw1 <= mw0;
      mv0 <= in_valid;
      mw0 <= in_words[src_sel*DW +: DW] ^ tx_keys[src_sel*DW +: DW];
    end
  end

  task automatic check_val(string tag, logic [BW-1:0] act_w, logic [BW-1:0] exp_w,
                           logic [NCH-1:0] act_v, logic [NCH-1:0] exp_v);
    checks++;
    if (act_w !== exp_w || act_v !== exp_v) begin
      fails++;
      $display("FAIL %s: words=%h valid=%b expected words=%h valid=%b", tag, act_w, act_v, exp_w, exp_v);
    end
  endtask

  task automatic check_model(string tag);
    logic [BW-1:0] ew = '0;
    logic [NCH-1:0] ev = '0;
    if (mv1) begin
      ev[dst_sel] = 1'b1;
      ew[dst_sel*DW +: DW] = mw1 ^ rx_keys[dst_sel*DW +: DW];
    end
    check_val(tag, out_words, ew, out_valid, ev);
  endtask

  task automatic step(bit v, logic [1:0] s, logic [1:0] d, logic [BW-1:0] iw,
                      logic [BW-1:0] tk, logic [BW-1:0] rk, string tag);
    @(negedge clk);
    in_valid = v; src_sel = s; dst_sel = d; in_words = iw; tx_keys = tk; rx_keys = rk;
    #1;
    check_model(tag);
  endtask

  function automatic logic [BW-1:0] rnd_bus();
    return {$urandom, $urandom};
  endfunction

  logic [DW-1:0] plain_h [0:63];
  logic [DW-1:0] key_h   [0:63];
  logic [1:0]    src_h   [0:63];

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    #1 check_val("R1 reset", out_words, '0, out_valid, '0);
    @(negedge clk); rst = 0;

    // R10 worked case, with R4 latency
    step(1, 2'd2, 2'd3, {8'hFF, 8'h00, 8'hF0, 8'h0F}, {4{8'h0F}}, {4{8'h0F}}, "R10 send");
    step(0, 2'd0, 2'd3, '0, {4{8'h0F}}, {4{8'h0F}}, "R4 one edge");
    check_val("R4 not early", out_words, '0, out_valid, '0);
    step(0, 2'd0, 2'd3, '0, {4{8'h0F}}, {4{8'h0F}}, "R10 arrive");
    check_val("R10 output D", out_words, '0, out_valid, 4'b1000);
    step(0, 2'd0, 2'd3, '0, {4{8'h0F}}, {4{8'h0F}}, "R4 not late");
    check_val("R4 gone", out_words, '0, out_valid, '0);

    // exhaustive select sweep: R2 R3 R5 R6 R7 R9
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++)
        for (int v = 0; v < 2; v++)
          for (int r = 0; r < 4; r++)
            step(v[0], s[1:0], d[1:0], rnd_bus(), rnd_bus(), rnd_bus(), "R2/R3/R5/R6/R9 sweep");

    // R8: matching receiver key restores plain word
    for (int i = 0; i < 40; i++) begin
      logic [BW-1:0] iw = rnd_bus();
      logic [BW-1:0] tk = rnd_bus();
      logic [BW-1:0] rk = rnd_bus();
      logic [1:0] s = 2'($urandom);
      logic [1:0] d = 2'($urandom);
      plain_h[i] = iw[s*DW +: DW];
      key_h[i]   = tk[s*DW +: DW];
      src_h[i]   = s;
      if (i >= 2) rk[d*DW +: DW] = key_h[i-2];
      step(1, s, d, iw, tk, rk, "R8 model");
      if (i >= 2) begin
        checks++;
        if (out_words[d*DW +: DW] !== plain_h[i-2] || out_valid[d] !== 1'b1) begin
          fails++;
          $display("FAIL R8: got %h expected %h", out_words[d*DW +: DW], plain_h[i-2]);
        end
      end
    end

    // R7: back-to-back random selects and keys in arrival cycle
    for (int i = 0; i < 1500; i++)
      step(1'($urandom), 2'($urandom), 2'($urandom), rnd_bus(), rnd_bus(), rnd_bus(), "R7 random");

    // R1: reset with words in flight
    step(1, 2'd1, 2'd0, rnd_bus(), rnd_bus(), rnd_bus(), "R1 preload");
    step(1, 2'd2, 2'd1, rnd_bus(), rnd_bus(), rnd_bus(), "R1 preload");
    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0; in_valid = 0;
    #1 check_val("R1 flush", out_words, '0, out_valid, '0);
    step(0, 2'd0, 2'd2, rnd_bus(), rnd_bus(), rnd_bus(), "R1 after flush");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(1_500_000ns);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule